// File: doc/BRIEF.md
# Sensor configuration shift-register loader

This block writes a configuration word into the control register of an image sensor over a bare three-wire serial link. The link has no chip select. The block drives a serial clock and a data line and sends the word one bit per serial-clock period. It then raises a dedicated load strobe, which tells the sensor to copy its shift chain into the active register. The host side makes one request at a time. Each request carries the word, the number of bits to send and an echo-mode flag. The block reports busy while it works and gives a single done pulse at the end.

The bits go out in reverse of the stored order: the highest bit that is in use goes first and bit 0 goes last. In echo mode the block also listens to the sensor's return line while the new word is shifted in. That line carries the previous register contents. The block collects these bits into a readback word and compares them against the word it wrote last time, so that software can confirm the earlier write took effect.

Top module: `cfg_shift_loader`

## Requirements
- R1: After reset, busy, done, sclk and sload are low, and rb_word and rb_match are zero.
- R2: A request (req_valid high while busy is low) is accepted on the next clock edge. Busy stays high from that edge until the cycle after done.
- R3: The block sends N bits, each lasting 2*HALF_DIV clock cycles, with sclk low for the first half and high for the second. Data changes only while sclk is low. Bit N-1 of req_word is sent first and bit 0 last. The done pulse comes (2*N+3)*HALF_DIV cycles after the accepting edge.
- R4: N equals req_len when 1 <= req_len <= WORD_W. A req_len of 0, or one above WORD_W, sends WORD_W bits.
- R5: sload rises HALF_DIV cycles after the last falling edge of sclk and stays high for 2*HALF_DIV cycles. Throughout that time sclk stays low and sdata keeps the last bit.
- R6: done is high for exactly one cycle, the cycle right after sload falls. Busy is low on the following cycle.
- R7: A request that arrives while busy is high is ignored. The word in flight is unchanged and no extra transfer follows.
- R8: In echo mode, rb_word is cleared when the request is accepted. The level on secho just before each rising sclk edge is then shifted into rb_word bit 0, and the earlier bits move up. As a result, rb_word[N-1:0] holds the echoed bits in stored order. Without echo mode, rb_word and rb_match keep their values.
- R9: In echo mode, rb_match is valid during done. It is 1 exactly when rb_word equals the low N bits of the word accepted by the previous request. Before any request completes, that previous word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_word | input | WORD_W | Configuration word |
| req_len | input | clog2(WORD_W+1) | Number of bits to send |
| req_echo | input | 1 | Capture and compare the returned bits |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock to the sensor |
| sdata | output | 1 | Serial data to the sensor |
| sload | output | 1 | Load strobe to the sensor |
| secho | input | 1 | Return line from the sensor |
| rb_word | output | WORD_W | Captured echo bits |
| rb_match | output | 1 | Echo equals the previously written word |

## Verification
The hardest case to reach is a readback compare that should fail, or should succeed across two requests of different lengths. To get there, the bench keeps its own model of the sensor's shift chain. The model is fed from sdata and drives secho. The bench can also invert the return line on chosen requests to force a mismatch. Sweeping every 8-bit word, and then every length field value including the clamped ones, makes rb_match move through both outcomes after words of varied lengths.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    LD_IDLE,
    LD_SHIFT,
    LD_HOLD,
    LD_STROBE,
    LD_FINISH
  } ld_state_e;
endpackage

// File: rtl/half_tick_gen.sv
module half_tick_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV) + 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [LEN_W-1:0]  eff_len,
  input  logic              shift,
  output logic              sdata
);
  logic [WORD_W-1:0] sh_q, sh_d;

  // Align bit eff_len-1 to the top so it leaves first.
  always_comb begin
    if (load)       sh_d = word << (LEN_W'(WORD_W) - eff_len);
    else if (shift) sh_d = {sh_q[WORD_W-2:0], 1'b0};
    else            sh_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sdata = sh_q[WORD_W-1];
endmodule

// File: rtl/echo_readback.sv
module echo_readback #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              bit_in,
  input  logic              compare,
  input  logic [WORD_W-1:0] ref_word,
  output logic [WORD_W-1:0] rb_word,
  output logic              rb_match
);
  logic [WORD_W-1:0] rb_q, rb_d;
  logic              match_q, match_d;

  always_comb begin
    rb_d    = rb_q;
    match_d = match_q;
    if (clear)        rb_d = '0;
    else if (capture) rb_d = {rb_q[WORD_W-2:0], bit_in};
    if (compare)      match_d = (rb_q == ref_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q    <= '0;
      match_q <= 1'b0;
    end else begin
      rb_q    <= rb_d;
      match_q <= match_d;
    end
  end

  assign rb_word  = rb_q;
  assign rb_match = match_q;
endmodule

// File: rtl/cfg_shift_loader.sv
module cfg_shift_loader
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [WORD_W-1:0]            req_word,
  input  logic [$clog2(WORD_W+1)-1:0]  req_len,
  input  logic                         req_echo,
  output logic                         busy,
  output logic                         done,
  output logic                         sclk,
  output logic                         sdata,
  output logic                         sload,
  input  logic                         secho,
  output logic [WORD_W-1:0]            rb_word,
  output logic                         rb_match
);
  localparam int LEN_W = $clog2(WORD_W + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  ld_state_e         st_q, st_d;
  logic              ph_q, ph_d;
  logic              sclk_q, sclk_d;
  logic              sload_q, sload_d;
  logic [LEN_W-1:0]  bits_q, bits_d;
  logic [LEN_W-1:0]  eff_q, eff_d;
  logic              echo_q, echo_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [WORD_W-1:0] prev_q, prev_d;

  logic              accept, tick, tx_shift, cap_en, cmp_en;
  logic [LEN_W-1:0]  req_eff;
  logic [WORD_W-1:0] len_mask;

  assign accept  = req_valid && (st_q == LD_IDLE);
  assign req_eff = (req_len == '0 || req_len > LEN_W'(WORD_W)) ? LEN_W'(WORD_W) : req_len;

  always_comb begin
    for (int i = 0; i < WORD_W; i++) len_mask[i] = (i < int'(eff_q));
  end

  half_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_core_n), .run(st_q != LD_IDLE), .tick(tick)
  );

  tx_serializer #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_n(rst_core_n), .load(accept), .word(req_word),
    .eff_len(req_eff), .shift(tx_shift), .sdata(sdata)
  );

  echo_readback #(.WORD_W(WORD_W)) u_rb (
    .clk(clk), .rst_n(rst_core_n), .clear(accept && req_echo),
    .capture(cap_en), .bit_in(secho), .compare(cmp_en),
    .ref_word(prev_q & len_mask), .rb_word(rb_word), .rb_match(rb_match)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    sclk_d   = sclk_q;
    sload_d  = sload_q;
    bits_d   = bits_q;
    eff_d    = eff_q;
    echo_d   = echo_q;
    word_d   = word_q;
    prev_d   = prev_q;
    tx_shift = 1'b0;
    cap_en   = 1'b0;
    cmp_en   = 1'b0;
    unique case (st_q)
      LD_IDLE: begin
        if (accept) begin
          st_d   = LD_SHIFT;
          ph_d   = 1'b0;
          bits_d = req_eff;
          eff_d  = req_eff;
          echo_d = req_echo;
          word_d = req_word;
        end
      end
      LD_SHIFT: begin
        if (tick) begin
          if (!ph_q) begin
            sclk_d = 1'b1;
            ph_d   = 1'b1;
            cap_en = echo_q;
          end else begin
            sclk_d = 1'b0;
            ph_d   = 1'b0;
            if (bits_q == LEN_W'(1)) begin
              st_d = LD_HOLD;
            end else begin
              tx_shift = 1'b1;
              bits_d   = bits_q - LEN_W'(1);
            end
          end
        end
      end
      LD_HOLD: begin
        if (tick) begin
          sload_d = 1'b1;
          ph_d    = 1'b0;
          st_d    = LD_STROBE;
        end
      end
      LD_STROBE: begin
        if (tick) begin
          if (!ph_q) begin
            ph_d = 1'b1;
          end else begin
            ph_d    = 1'b0;
            sload_d = 1'b0;
            cmp_en  = echo_q;
            st_d    = LD_FINISH;
          end
        end
      end
      LD_FINISH: begin
        prev_d = word_q;
        st_d   = LD_IDLE;
      end
      default: st_d = LD_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q    <= LD_IDLE;
      ph_q    <= 1'b0;
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
      bits_q  <= '0;
      eff_q   <= '0;
      echo_q  <= 1'b0;
      word_q  <= '0;
      prev_q  <= '0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      sclk_q  <= sclk_d;
      sload_q <= sload_d;
      bits_q  <= bits_d;
      eff_q   <= eff_d;
      echo_q  <= echo_d;
      word_q  <= word_d;
      prev_q  <= prev_d;
    end
  end

  assign busy  = (st_q != LD_IDLE);
  assign done  = (st_q == LD_FINISH);
  assign sclk  = sclk_q;
  assign sload = sload_q;
endmodule

// File: rtl/cfg_shift_loader_chk.sv
module cfg_shift_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdata,
  input logic sload,
  input logic rb_match
);
  assert_sclk_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> busy);

  assert_data_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  assert_strobe_clock_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sload && sclk));

  assert_strobe_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sload |-> $stable(sdata));

  assert_done_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sload) |-> done);

  assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_match_held_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $stable(rb_match));
endmodule

bind cfg_shift_loader cfg_shift_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk(sclk),
  .sdata(sdata), .sload(sload), .rb_match(rb_match)
);

// File: tb/cfg_shift_loader_test.sv
module cfg_shift_loader_test;
  localparam int W = 8;
  localparam int H = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [7:0] req_word;
  logic [3:0] req_len;
  logic       req_echo;
  logic       busy, done, sclk, sdata, sload, secho, rb_match;
  logic [7:0] rb_word;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  cfg_shift_loader #(.WORD_W(W), .HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .req_len(req_len), .req_echo(req_echo), .busy(busy), .done(done),
    .sclk(sclk), .sdata(sdata), .sload(sload), .secho(secho),
    .rb_word(rb_word), .rb_match(rb_match)
  );

  // sensor model: shift chain fed by sdata, echo from its tail
  logic [7:0] sens = 8'h00;
  logic [7:0] rx = 8'h00;
  int         rises = 0;
  int         mlen = 8;
  logic       flip = 1'b0;
  assign secho = flip ^ sens[mlen-1];

  always @(posedge sclk) begin
    rx    = {rx[6:0], sdata};
    sens  = {sens[6:0], sdata};
    rises = rises + 1;
  end

  logic [7:0] prev_word = 8'h00;
  logic [7:0] last_rb   = 8'h00;
  logic       last_mt   = 1'b0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic run_txn(input logic [7:0] w, input logic [3:0] ln,
                         input logic ec, input logic fl, input logic ign);
    int eff, m, cnt, gap, width, done_n, cyc, overlap;
    logic dfall, seen, p_sclk, p_sload, got_match;
    logic [7:0] sb, eb, got_rb;
    eff = (ln == 0 || ln > W) ? W : int'(ln);
    m   = (1 << eff) - 1;
    @(negedge clk);
    rx = 8'h00; rises = 0; mlen = eff; flip = fl; sb = sens;
    req_valid = 1'b1; req_word = w; req_len = ln; req_echo = ec;
    @(negedge clk);
    chk("R2 busy after accept", busy, 1);
    req_valid = 1'b0;
    cnt = 0; gap = -1; width = 0; done_n = 0; cyc = 0; overlap = 0;
    dfall = 1'b0; seen = 1'b0; p_sclk = 1'b0; p_sload = 1'b0;
    got_rb = 8'h00; got_match = 1'b0;
    while (!seen) begin
      if (sclk && sload) overlap++;
      if (p_sclk && !sclk) cnt = 1;
      else if (!p_sload && sload) gap = cnt;
      else if (!sload) cnt++;
      if (sload) width++;
      if (p_sload && !sload) dfall = done;
      if (done) begin
        done_n++; seen = 1'b1; got_rb = rb_word; got_match = rb_match;
      end
      p_sclk = sclk; p_sload = sload;
      if (!seen) begin
        @(negedge clk);
        cyc++;
        if (ign && cyc == 3) begin
          req_valid = 1'b1; req_word = ~w; req_len = 4'd3; req_echo = ~ec;
        end
        if (cyc == 4) req_valid = 1'b0;
      end
    end
    chk("R3 bit count", rises, eff);
    chk("R3 bit order", rx & m, w & m);
    chk("R3 done timing", cyc, (2 * eff + 3) * H);
    chk("R4 length field honoured", rises, eff);
    chk("R5 strobe gap", gap, H);
    chk("R5 strobe width", width, 2 * H);
    chk("R5 no clock during strobe", overlap, 0);
    chk("R6 done at strobe fall", dfall, 1);
    @(negedge clk);
    chk("R6 busy drops", busy, 0);
    chk("R6 single done", done_n + int'(done), 1);
    if (ec) begin
      eb = (fl ? ~sb : sb) & 8'(m);
      chk("R8 readback word", got_rb, eb);
      chk("R9 compare flag", got_match, (eb == (prev_word & 8'(m))));
      last_rb = eb; last_mt = (eb == (prev_word & 8'(m)));
    end else begin
      chk("R8 readback kept", got_rb, last_rb);
      chk("R8 flag kept", got_match, last_mt);
    end
    if (ign) begin
      int idle_bad = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (busy || sclk || sload) idle_bad++;
      end
      chk("R7 ignored request left no transfer", idle_bad, 0);
    end
    prev_word = w;
    flip = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_word = 8'h00; req_len = 4'd0; req_echo = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 sclk", sclk, 0);
    chk("R1 sload", sload, 0);
    chk("R1 rb_word", rb_word, 0);
    chk("R1 rb_match", rb_match, 0);
    // first echo: sensor and previous word both zero
    run_txn(8'hA5, 4'd8, 1'b1, 1'b0, 1'b0);
    for (int v = 0; v < 256; v++)
      run_txn(8'(v), 4'd8, logic'(v % 2), logic'(v % 37 == 5), logic'(v % 50 == 7));
    for (int l = 0; l < 16; l++) begin
      run_txn(8'h3C ^ 8'(l * 17), 4'(l), 1'b1, 1'b0, 1'b0);
      run_txn(8'hC3 ^ 8'(l), 4'(l), 1'b1, logic'(l % 3 == 1), 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule